// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a down-counter that must be refreshed inside a time window. A 7-bit count decrements on every tick of a prescaler that divides the peripheral clock. A reset request goes out when the count falls below 0x40. A reset request also goes out when software refreshes the count too early, while the count is still above a programmable window limit. A refresh with the top count bit clear also requests a reset, which gives software a way to force one.

An early-warning flag is raised when the count arrives at 0x40. It can also drive an interrupt line, so that a service routine still has one tick period to refresh the counter. The activation bit can only be set. It clears only through the block's own reset. The counter runs whether or not the watchdog is active.

Software reaches the block through a flat register port with a write strobe, a register select and data. The same select codes apply for reads.

Top module: `win_watchdog`

## Requirements
- R1: Register selects are 0 for control, 1 for configuration and 2 for status. Control holds the active bit at bit 7 and the count at bits 6:0. Configuration holds the window at bits 6:0, the timebase at bits 8:7 and the interrupt enable at bit 9. Status holds the early flag at bit 0. After reset the control register reads 0x07F, configuration reads 0x07F, status reads 0, and `rst_req` and `irq` are low.
- R2: The count decrements by one on every prescaler tick, whether or not the watchdog is active. A tick comes once every BASE_DIV x 2^timebase clock cycles. A prescaler tick does not restart when a control write occurs.
- R3: Once the active bit is set, a control write with bit 7 clear leaves it set.
- R4: While active, the count passing from 0x40 to 0x3F raises `rst_req`. While inactive, the count passing from 0x40 to 0x3F never raises `rst_req`.
- R5: A control write that leaves the watchdog active with count bit 6 clear raises `rst_req` on the next cycle.
- R6: While active, a control write raises `rst_req` if the count before the write is greater than the window. A write made when the count equals the window does not raise `rst_req`.
- R7: The early flag is set when a tick brings the count to 0x40. `irq` equals the flag ANDed with the interrupt enable.
- R8: A status write with bit 0 clear clears the early flag. A status write with bit 0 set has no effect on the flag.
- R9: `rst_req` is high for a single clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | DATA_W (10) | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | DATA_W (10) | Read data of the selected register |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Early-warning interrupt |

## Verification
Three kinds of fault in the count register show at the ports: a lost decrement, a missed wrap, or a stale value. Each shows in the control readback within one tick period. Each also shifts the moment that `rst_req` pulses after an expiry refresh by at least one tick. A wrong window comparison shows on the very cycle after the offending control write. For this reason the window limit is probed at equality and at one count above it. A flag that does not stay set or does not clear shows in the status readback right after the status write. Because `irq` follows the flag combinationally, a flag fault also appears on `irq` in the same cycle.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_CFG  = 2'd1,
      SEL_STAT = 2'd2
   } wdg_sel_e;
endpackage

// File: rtl/wdg_prescaler.sv
`timescale 1ns/1ps
module wdg_prescaler #(
   parameter int BASE_DIV = 4096,
   parameter int TB_W     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TB_W-1:0] tb,
   output logic            tick
);
   localparam int BASE_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
   localparam int SUB_W  = (1 << TB_W) - 1;

   generate
      if (BASE_DIV < 2) begin : g_bad_div
         $error("wdg_prescaler: BASE_DIV must be at least 2");
      end
      if (TB_W < 1 || TB_W > 3) begin : g_bad_tb
         $error("wdg_prescaler: TB_W must be 1 to 3");
      end
   endgenerate

   logic [BASE_W-1:0] base_q;
   logic [SUB_W-1:0]  sub_q;
   logic [SUB_W:0]    one_sh;
   logic [SUB_W-1:0]  mask;
   logic              base_wrap;

   assign base_wrap = (base_q == BASE_W'(BASE_DIV - 1));
   assign one_sh    = (SUB_W+1)'(1) << tb;
   assign mask      = SUB_W'(one_sh - (SUB_W+1)'(1));
   assign tick      = base_wrap && ((sub_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         sub_q  <= '0;
      end else begin
         base_q <= base_wrap ? '0 : base_q + 1'b1;
         if (base_wrap) sub_q <= sub_q + 1'b1;
      end
   end

   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/wdg_core.sv
`timescale 1ns/1ps
module wdg_core #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ctrl_wr,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic             wr_act,
   input  logic [CNT_W-1:0] win,
   output logic [CNT_W-1:0] cnt,
   output logic             active,
   output logic             rst_req,
   output logic             early_hit
);
   localparam logic [CNT_W-1:0] EXP_VAL = CNT_W'(1) << (CNT_W - 1);
   localparam logic [CNT_W-1:0] PRE_VAL = EXP_VAL + CNT_W'(1);

   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("wdg_core: CNT_W must be at least 3");
      end
   endgenerate

   logic act_next, bad_write, expire;

   assign act_next  = active | (ctrl_wr & wr_act);
   assign bad_write = ctrl_wr && act_next && (!wr_cnt[CNT_W-1] || (cnt > win));
   assign expire    = !ctrl_wr && tick && active && (cnt == EXP_VAL);
   assign early_hit = !ctrl_wr && tick && (cnt == PRE_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= {CNT_W{1'b1}};
         active  <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         active  <= act_next;
         rst_req <= (bad_write || expire) && !rst_req;
         if (ctrl_wr)   cnt <= wr_cnt;
         else if (tick) cnt <= cnt - 1'b1;
      end
   end

   assert_act_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> active);
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ctrl_wr) |=> cnt == CNT_W'($past(cnt) - 1'b1));
   assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ctrl_wr) |=> $stable(cnt));
   assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !(ctrl_wr && wr_act)) |=> !rst_req);
   assert_sw_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ctrl_wr && !wr_cnt[CNT_W-1] && !rst_req) |=> rst_req);
   assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
endmodule

// File: rtl/wdg_status.sv
`timescale 1ns/1ps
module wdg_status (
   input  logic clk,
   input  logic rst_n,
   input  logic early_hit,
   input  logic clr_wr,
   input  logic clr_val,
   input  logic ewi,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag <= 1'b0;
      else if (early_hit)         flag <= 1'b1;
      else if (clr_wr && !clr_val) flag <= 1'b0;
   end

   assign irq = flag & ewi;

   assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      early_hit |=> flag);
   assert_flag_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(clr_wr && !clr_val)) |=> flag);
endmodule

// File: rtl/win_watchdog.sv
`timescale 1ns/1ps
module win_watchdog
   import wdg_pkg::*;
#(
   parameter int BASE_DIV = 4096,
   parameter int CNT_W    = 7,
   parameter int TB_W     = 2,
   parameter int DATA_W   = CNT_W + TB_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              rst_req,
   output logic              irq
);
   localparam int TB_LO  = CNT_W;
   localparam int EWI_BT = CNT_W + TB_W;

   generate
      if (DATA_W != CNT_W + TB_W + 1) begin : g_bad_w
         $error("win_watchdog: DATA_W must equal CNT_W + TB_W + 1");
      end
   endgenerate

   logic [CNT_W-1:0] win_q, cnt;
   logic [TB_W-1:0]  tb_q;
   logic             ewi_q, tick, active, early_hit, flag;
   logic             ctrl_wr, cfg_wr, stat_wr;

   assign ctrl_wr = wr_en && (wdg_sel_e'(wr_sel) == SEL_CTRL);
   assign cfg_wr  = wr_en && (wdg_sel_e'(wr_sel) == SEL_CFG);
   assign stat_wr = wr_en && (wdg_sel_e'(wr_sel) == SEL_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= {CNT_W{1'b1}};
         tb_q  <= '0;
         ewi_q <= 1'b0;
      end else if (cfg_wr) begin
         win_q <= wr_data[CNT_W-1:0];
         tb_q  <= wr_data[TB_LO +: TB_W];
         ewi_q <= wr_data[EWI_BT];
      end
   end

   wdg_prescaler #(.BASE_DIV(BASE_DIV), .TB_W(TB_W)) u_pre (
      .clk (clk), .rst_n (rst_n), .tb (tb_q), .tick (tick)
   );

   wdg_core #(.CNT_W(CNT_W)) u_core (
      .clk (clk), .rst_n (rst_n), .tick (tick),
      .ctrl_wr (ctrl_wr), .wr_cnt (wr_data[CNT_W-1:0]), .wr_act (wr_data[CNT_W]),
      .win (win_q), .cnt (cnt), .active (active),
      .rst_req (rst_req), .early_hit (early_hit)
   );

   wdg_status u_stat (
      .clk (clk), .rst_n (rst_n), .early_hit (early_hit),
      .clr_wr (stat_wr), .clr_val (wr_data[0]), .ewi (ewi_q),
      .flag (flag), .irq (irq)
   );

   always_comb begin
      rd_data = '0;
      case (wdg_sel_e'(rd_sel))
         SEL_CTRL: rd_data = DATA_W'({active, cnt});
         SEL_CFG:  rd_data = {ewi_q, tb_q, win_q};
         SEL_STAT: rd_data = DATA_W'(flag);
         default:  rd_data = '0;
      endcase
   end

   assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && ewi_q));
endmodule

// File: tb/win_watchdog_bench.sv
`timescale 1ns/1ps
module win_watchdog_bench;
   localparam int DW = 10;
   logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd0, rd_sel = 2'd0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          rst_req, irq;
   int            n_chk = 0, n_fail = 0, cyc = 0;

   always #2.5 clk = ~clk;

   win_watchdog #(.BASE_DIV(4)) u_win_watchdog (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
      .wr_data (wr_data), .rd_sel (rd_sel), .rd_data (rd_data),
      .rst_req (rst_req), .irq (irq)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [DW-1:0] v);
      rd_sel = sel; #0.5; v = rd_data;
   endtask

   task automatic t_reset;
      logic [DW-1:0] v;
      rd(2'd0, v); check(v == 10'h07F, "R1 ctrl", v, 10'h07F);
      rd(2'd1, v); check(v == 10'h07F, "R1 cfg", v, 10'h07F);
      rd(2'd2, v); check(v == 10'h000, "R1 stat", v, 0);
      check(!rst_req && !irq, "R1 outputs", {rst_req, irq}, 0);
   endtask

   task automatic t_free_run;
      logic [DW-1:0] a, b;
      bit seen = 0;
      rd(2'd0, a);
      repeat (32) @(negedge clk);
      rd(2'd0, b);
      check(7'(a[6:0] - b[6:0]) == 7'd8, "R2 free run", 7'(a[6:0] - b[6:0]), 8);
      repeat (300) begin @(negedge clk); if (rst_req) seen = 1; end
      check(!seen, "R4 inactive expiry", seen, 0);
      rd(2'd2, a);
      check(a[0] == 1'b1 && !irq, "R7 flag with irq masked", {a[0], irq}, 2'b10);
   endtask

   task automatic t_flag_clear;
      logic [DW-1:0] v;
      wr(2'd2, 10'h001); rd(2'd2, v);
      check(v[0] == 1'b1, "R8 write one ignored", v[0], 1);
      wr(2'd2, 10'h000); rd(2'd2, v);
      check(v[0] == 1'b0, "R8 write zero clears", v[0], 0);
   endtask

   task automatic t_timebase;
      logic [DW-1:0] a, b;
      wr(2'd1, 10'h17F);
      repeat (40) @(negedge clk);
      rd(2'd0, a);
      repeat (64) @(negedge clk);
      rd(2'd0, b);
      check(7'(a[6:0] - b[6:0]) == 7'd4, "R2 timebase 2", 7'(a[6:0] - b[6:0]), 4);
      wr(2'd1, 10'h27F);
   endtask

   task automatic t_expiry;
      int n = 0;
      wr(2'd0, 10'h0C3);
      while (!rst_req && n < 40) begin @(negedge clk); n++; end
      check(n >= 13 && n <= 16, "R4 expiry delay", n, 16);
      check(irq == 1'b1, "R7 irq at expiry", irq, 1);
      @(negedge clk);
      check(!rst_req, "R9 single pulse", rst_req, 0);
      wr(2'd2, 10'h000);
      check(!irq, "R8 irq cleared", irq, 0);
   endtask

   task automatic t_sticky;
      logic [DW-1:0] v;
      wr(2'd0, 10'h07F); rd(2'd0, v);
      check(v[7] == 1'b1, "R3 active sticky", v[7], 1);
      check(!rst_req, "R3 no reset", rst_req, 0);
   endtask

   task automatic t_sw_reset;
      wr(2'd0, 10'h0B0);
      check(rst_req, "R5 forced reset", rst_req, 1);
      @(negedge clk);
      check(!rst_req, "R9 forced pulse ends", rst_req, 0);
   endtask

   task automatic t_window;
      logic [DW-1:0] v;
      int n;
      wr(2'd0, 10'h0FF);
      check(!rst_req, "R6 legal refresh", rst_req, 0);
      wr(2'd1, 10'h1D0);
      wr(2'd0, 10'h0FF);
      check(rst_req, "R6 early refresh", rst_req, 1);
      n = 0;
      do begin @(negedge clk); rd(2'd0, v); n++; end while (v[6:0] != 7'h50 && n < 3000);
      wr(2'd0, 10'h0FF);
      check(!rst_req, "R6 refresh at window", rst_req, 0);
      n = 0;
      do begin @(negedge clk); rd(2'd0, v); n++; end while (v[6:0] != 7'h51 && n < 3000);
      wr(2'd0, 10'h0FF);
      check(rst_req, "R6 refresh one above window", rst_req, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_free_run;
      t_flag_clear;
      t_timebase;
      t_expiry;
      t_sticky;
      t_sw_reset;
      t_window;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule